// File: doc/BRIEF.md
# Flash Status Pin Controller

This block drives the active-low status output of a flash device. After reset the pin gives a plain ready/busy level: it is low while the internal write state machine is busy and high when the device is ready. A two-write configuration command can instead set the pin to interrupt behaviour. In that case it idles high and gives one fixed-width low pulse when an erase completes, when a program completes, or when either completes.

The command port is a plain write strobe with a data byte. Every write is taken in the cycle it is presented, so the port has no back-pressure and no ready signal. A write of `B8h` arms the decoder, and the next write is taken as the configuration byte. Only bits 1:0 of that byte are used; the other six bits are masked. The width of the low pulse is the parameter `PULSE_W`, given in clock cycles. Its default is 25 cycles, about 250 ns at 100 MHz.

Top module: `flash_sts_ctrl`

## Requirements
- R1: After reset the mode is 00 (level), the decoder is not armed and, with the busy flag low, `sts_n` is high.
- R2: A write of `B8h` followed by any next write loads bits 1:0 of that second byte into the mode. The new mode governs `sts_n` from the cycle after the second write.
- R3: Bits 7:2 of the configuration byte have no effect on the mode loaded.
- R4: A write that neither follows an arming `B8h` write nor is itself `B8h` leaves the mode unchanged.
- R5: In mode 00, `sts_n` equals the inverse of the busy flag sampled one clock earlier. Completion strobes have no effect.
- R6: In mode 01, an erase completion strobe drives `sts_n` low from the next cycle for exactly `PULSE_W` cycles. Program strobes have no effect.
- R7: In mode 10, a program completion strobe gives the same pulse. Erase strobes have no effect.
- R8: In mode 11, either completion strobe gives the pulse.
- R9: In modes 01, 10 and 11, `sts_n` is high whenever no pulse is in progress, whatever the busy flag shows.
- R10: A qualifying strobe that arrives during a pulse restarts the pulse at its full width.
- R11: Loading a configuration byte ends any pulse in progress. A strobe in that same cycle is ignored.
- R12: A reset that falls between the `B8h` write and the configuration byte abandons the command. The next write is then decoded as a first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte write strobe, one per cycle |
| cmd_data | input | 8 | Command byte |
| wsm_busy | input | 1 | Write state machine busy flag |
| erase_done | input | 1 | Single-cycle erase completion strobe |
| prog_done | input | 1 | Single-cycle program completion strobe |
| sts_n | output | 1 | Active-low status pin |

## Verification
The assertions assume that the completion strobes and the command strobe are sampled synchronously to `clk`, and that a configuration byte arrives only as the write right after an arming `B8h`. They make no assumption about how often strobes repeat or how they overlap. The stimulus drives every input just after a falling edge, so each one is stable across the rising edge. The random phase lets erase and program strobes coincide with each other, with busy changes and with configuration writes. It biases command bytes toward `B8h`, so that arming, back-to-back `B8h` pairs and mode changes during pulses all occur.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int NSRC = 2;          // completion sources: erase (bit 0), program (bit 1)
  localparam logic [7:0] CFG_CMD = 8'hB8;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_PROG  = 2'b10,
    MODE_BOTH  = 2'b11
  } sts_mode_e;
endpackage

// File: rtl/sts_cmd_decode.sv
module sts_cmd_decode
  import sts_pkg::*;
#(
  parameter logic [7:0] ARM_CODE = CFG_CMD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  output logic       cfg_load,
  output logic [1:0] cfg_value
);
  logic armed_q;

  // second write of the pair is the configuration byte
  assign cfg_load  = cmd_we && armed_q;
  assign cfg_value = cmd_data[1:0];   // upper six bits masked

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (cmd_we) begin
      armed_q <= armed_q ? 1'b0 : (cmd_data == ARM_CODE);
    end
  end
endmodule

// File: rtl/sts_pulse_gen.sv
module sts_pulse_gen #(
  parameter int PULSE_W = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fire,
  output logic active
);
  localparam int CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(PULSE_W);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= FULL;                 // restart at full width
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/flash_sts_ctrl.sv
module flash_sts_ctrl
  import sts_pkg::*;
#(
  parameter int PULSE_W = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic       wsm_busy,
  input  logic       erase_done,
  input  logic       prog_done,
  output logic       sts_n
);
  logic            cfg_load;
  logic [1:0]      cfg_value;
  sts_mode_e       mode_q;
  logic            busy_q;
  logic [NSRC-1:0] done_vec;
  logic [NSRC-1:0] hit;
  logic            fire;
  logic            pulse_on;

  sts_cmd_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .cmd_data (cmd_data),
    .cfg_load (cfg_load),
    .cfg_value(cfg_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LEVEL;
      busy_q <= 1'b0;
    end else begin
      busy_q <= wsm_busy;
      if (cfg_load) mode_q <= sts_mode_e'(cfg_value);
    end
  end

  // each mode bit enables one completion source
  assign done_vec = {prog_done, erase_done};
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = done_vec[g] & mode_q[g];
  end
  assign fire = |hit;

  sts_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cfg_load),
    .fire  (fire),
    .active(pulse_on)
  );

  assign sts_n = (mode_q == MODE_LEVEL) ? ~busy_q : ~pulse_on;
endmodule

// File: rtl/sts_chk.sv
module sts_chk #(
  parameter int PULSE_W = 25
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wsm_busy,
  input logic       erase_done,
  input logic       prog_done,
  input logic       sts_n,
  input logic       cfg_load,
  input logic [1:0] cfg_value,
  input logic [1:0] mode
);
  logic past_ok;
  int   run_q;
  logic qual;

  assign qual = (erase_done && mode[0]) || (prog_done && mode[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      run_q   <= 0;
    end else begin
      past_ok <= 1'b1;
      if (qual || cfg_load)             run_q <= 0;
      else if (mode != 2'b00 && !sts_n) run_q <= run_q + 1;
      else                              run_q <= 0;
    end
  end

  // R5
  lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode == 2'b00) |-> (sts_n == !$past(wsm_busy)));

  // R6
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !cfg_load) |=> !sts_n);

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (mode == $past(cfg_value)));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(mode));

  // R11
  pulse_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_value != 2'b00) |=> sts_n);

  // R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= PULSE_W);
endmodule

bind flash_sts_ctrl sts_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wsm_busy  (wsm_busy),
  .erase_done(erase_done),
  .prog_done (prog_done),
  .sts_n     (sts_n),
  .cfg_load  (cfg_load),
  .cfg_value (cfg_value),
  .mode      (mode_q)
);

// File: tb/flash_sts_ctrl_tb.sv
module flash_sts_ctrl_tb;
  localparam int W = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       wsm_busy = 1'b0;
  logic       erase_done = 1'b0;
  logic       prog_done = 1'b0;
  logic       sts_n;

  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  bit    chk_en = 1'b0;
  string cur_tag = "R1";

  // reference state derived from the requirements
  logic [1:0] m_mode;
  logic       m_armed;
  int         m_cnt;
  logic       m_busy;

  always #5 clk = ~clk;

  flash_sts_ctrl #(.PULSE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .wsm_busy(wsm_busy), .erase_done(erase_done), .prog_done(prog_done),
    .sts_n(sts_n)
  );

  function automatic logic exp_sts(logic [1:0] md, int cnt, logic bz);
    return (md == 2'b00) ? !bz : (cnt == 0);
  endfunction

  function automatic string mode_tag(logic [1:0] md);
    case (md)
      2'b00:   return "R5";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2'b00; m_armed = 1'b0; m_cnt = 0; m_busy = 1'b0;
    end else begin
      logic ld, fr;
      ld = cmd_we && m_armed;
      fr = (erase_done && m_mode[0]) || (prog_done && m_mode[1]);
      if (ld)              m_cnt = 0;
      else if (fr)         m_cnt = W;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      m_busy = wsm_busy;
      if (cmd_we) begin
        if (m_armed) begin m_mode = cmd_data[1:0]; m_armed = 1'b0; end
        else m_armed = (cmd_data == 8'hB8);
      end
    end
  end

  task automatic check(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: sts_n=%0b expected %0b at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en)
      check((cur_tag == "") ? mode_tag(m_mode) : cur_tag, sts_n,
            exp_sts(m_mode, m_cnt, m_busy));
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] b);
    cmd_we = 1'b1; cmd_data = b;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic strobe(logic er, logic pr);
    erase_done = er; prog_done = pr;
    @(negedge clk);
    erase_done = 1'b0; prog_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", sts_n, 1'b1);
    chk_en = 1'b1;

    // level mode following busy; strobes ignored
    cur_tag = "R5";
    wsm_busy = 1'b1; idle(3);
    strobe(1, 1);
    wsm_busy = 1'b0; idle(3);

    // non-arming writes leave level mode
    cur_tag = "R4";
    wr(8'h03); wr(8'h02); strobe(1, 1); wsm_busy = 1'b1; idle(2); wsm_busy = 1'b0; idle(2);

    // configuration byte with upper bits set -> mode 01
    cur_tag = "R3";
    wr(8'hB8); wr(8'hFD); idle(2);

    // erase pulse; explicit width count
    cur_tag = "R6";
    strobe(0, 1); idle(3);
    begin
      int lows;
      erase_done = 1'b1;
      @(negedge clk);
      erase_done = 1'b0;
      lows = 1;
      for (int i = 0; i < 40; i++) begin
        if (!sts_n) lows++;
        @(negedge clk);
      end
      lows = lows - (sts_n ? 1 : 0);
      check("R6", (lows == W), 1'b1);
    end

    // busy ignored in pulse mode
    cur_tag = "R9";
    wsm_busy = 1'b1; idle(5); wsm_busy = 1'b0; idle(2);

    cur_tag = "R2";
    wr(8'hB8); wr(8'h02); idle(1);
    cur_tag = "R7";
    strobe(1, 0); idle(2); strobe(0, 1); idle(W + 4);

    cur_tag = "R2";
    wr(8'hB8); wr(8'hB8); idle(1);     // second B8 is the config byte -> mode 00
    cur_tag = "R5";
    wsm_busy = 1'b1; idle(2); wsm_busy = 1'b0; idle(2);

    cur_tag = "R2";
    wr(8'hB8); wr(8'h03);
    cur_tag = "R8";
    strobe(1, 0); idle(W + 3); strobe(0, 1); idle(W + 3); strobe(1, 1); idle(W + 3);

    // retrigger mid-pulse
    cur_tag = "R10";
    strobe(1, 0); idle(10); strobe(0, 1); idle(W + 3);

    // mode change ends a pulse; strobe coinciding with the config byte ignored
    cur_tag = "R11";
    strobe(1, 0); idle(5);
    wr(8'hB8);
    cmd_we = 1'b1; cmd_data = 8'h01; erase_done = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; erase_done = 1'b0;
    check("R11", sts_n, 1'b1);
    idle(4);

    // reset between arming and config byte
    cur_tag = "R12";
    wr(8'hB8);
    do_reset();
    wr(8'h02); strobe(0, 1); idle(3);
    check("R12", sts_n, 1'b1);

    // constrained random phase
    cur_tag = "";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 9) == 0) wsm_busy = ~wsm_busy;
      erase_done = ($urandom_range(0, 19) == 0);
      prog_done  = ($urandom_range(0, 19) == 0);
      cmd_we     = ($urandom_range(0, 14) == 0);
      cmd_data   = $urandom_range(0, 1) ? 8'hB8 : 8'($urandom_range(0, 255));
      @(negedge clk);
    end
    cmd_we = 1'b0; erase_done = 1'b0; prog_done = 1'b0;
    idle(W + 2);

    chk_en = 1'b0;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run not complete, actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule